// File: doc/BRIEF.md
# Per-Rank Refresh Sequencer

One copy of this block sits beside each memory rank. It keeps a free-running cycle count and a refresh due time for its own rank. When the due time comes, it withdraws the rank from scheduling. It then waits until every access already issued to the rank has finished. Next it asks the command path to close all open banks, and after that it asks for the refresh command. Once the refresh cycle time has passed, it hands the rank back to the scheduler. Because each rank carries its own sequencer and its own due time, one rank can be refreshing while the others keep the data bus busy.

The scheduler reads the availability flag and stops sending new work to the rank while the flag is low. The command path turns the two request outputs into the real bank commands. It answers each request with a one-cycle done strobe. The first due time is taken from an input while reset is held. Later due times are spaced by exactly one programmed interval, so the refresh rate does not drift when draining takes longer.

Top module: `rank_refresh_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the state output reads 0 (idle), the availability flag is 1 and both requests are 0. The first due time is captured from `first_due_i` during reset.
- R2: The internal cycle count is 0 in the first cycle after reset release and increments once per cycle. When it equals the due time, the state goes to drain (code 1) at the next rising edge. For a first due time D, the availability flag therefore falls at the (D+1)-th rising edge after reset release. The in-flight count has no effect while the state is idle.
- R3: In drain the state holds as long as `inflight_i` is non-zero. It moves to precharge (code 2) at the first rising edge where `inflight_i` is zero.
- R4: In precharge with `open_banks_i` non-zero, `prea_req_o` is 1 until `prea_done_i` is sampled high. The state then becomes run (code 3).
- R5: In precharge with `open_banks_i` zero, the state stays in precharge for exactly one cycle, `prea_req_o` stays 0, and the state then becomes run.
- R6: `ref_req_o` is 1 from entry into run until `ref_done_i` is sampled high. The state then stays in run for max(`trc_i`,1) more cycles and returns to idle.
- R7: The availability flag is 1 exactly when the state is idle. Neither request is raised while the flag is 1.
- R8: Each time the count meets the due time, the due time advances by `interval_i`, whenever that refresh actually finishes. The second refresh therefore starts at rising edge D+I+1, provided the first one has finished by then.
- R9: A due time reached while the rank is away from idle is remembered. The rank then stays idle for exactly one cycle before it drains again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| first_due_i | input | CNT_W | First refresh due time, captured during reset |
| interval_i | input | CNT_W | Refresh interval in cycles |
| trc_i | input | RC_W | Refresh cycle time in cycles |
| inflight_i | input | INFL_W | Accesses to this rank still in flight |
| open_banks_i | input | BANK_W | Number of open banks in this rank |
| prea_done_i | input | 1 | Close-all-banks command has completed |
| ref_done_i | input | 1 | Refresh command has been issued |
| avail_o | output | 1 | Rank may take new work |
| prea_req_o | output | 1 | Request to close all banks |
| ref_req_o | output | 1 | Request to issue the refresh |
| state_o | output | 2 | Refresh state: 0 idle, 1 drain, 2 precharge, 3 run |

## Verification
The hardest case to reach is a due time that expires while the rank is still draining. That case only arises when the interval is short compared with the time the in-flight count stays non-zero. A directed test sets a short interval and holds `inflight_i` non-zero across the second expiry. It then checks that, once the refresh completes, the rank is available for exactly one cycle and drains again. The table cases vary how long the drain lasts, whether any bank is open, the precharge latency and the refresh cycle time. Each case also checks where the second refresh starts, which shows the due time is not measured from completion.

// File: rtl/rfsh_pkg.sv
// Shared types of the per-rank refresh sequencer.
// Assumes: state codes are visible at the top and must stay 0..3 in sequence order.
package rfsh_pkg;
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_DRAIN = 2'd1,
        RS_PRECH = 2'd2,
        RS_RUN   = 2'd3
    } rfsh_state_e;
endpackage

// File: rtl/rfsh_due_timer.sv
// Refresh due-time tracker: a free-running cycle count compared with a due register.
// The due register advances by one interval at every match, so the schedule never drifts.
// Assumes: idle_i is high only while the sequencer is idle; a pending expiry is kept
// until the sequencer next leaves idle.
module rfsh_due_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] first_due_i,
    input  logic [CNT_W-1:0] interval_i,
    input  logic             idle_i,
    output logic             due_o
);
    logic [CNT_W-1:0] now_q;
    logic [CNT_W-1:0] due_q;
    logic             pend_q;
    logic             hit;

    assign hit   = (now_q == due_q);
    assign due_o = hit | pend_q;

    // Cycle count and fixed-rate due time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q <= '0;
            due_q <= first_due_i;
        end else begin
            now_q <= now_q + 1'b1;
            if (hit) due_q <= due_q + interval_i;
        end
    end

    // Remember an expiry that lands while the rank is busy.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q | hit) & ~idle_i;
    end

    // R9
    busy_expiry_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !idle_i) |=> due_o);
endmodule

// File: rtl/rfsh_run_timer.sv
// Refresh cycle timer: started by the refresh done strobe, it expires after
// max(trc,1) cycles.
// Assumes: start_i is a single-cycle pulse while the timer is inactive.
module rfsh_run_timer #(
    parameter int RC_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [RC_W-1:0] trc_i,
    output logic            active_o,
    output logic            expire_o
);
    logic [RC_W-1:0] cnt_q;
    logic            act_q;

    assign active_o = act_q;
    assign expire_o = act_q && (cnt_q <= 1);

    // Load on start, count down while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_i) begin
            act_q <= 1'b1;
            cnt_q <= trc_i;
        end else if (act_q) begin
            if (cnt_q <= 1) act_q <= 1'b0;
            else            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R6
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !expire_o) |=> act_q);
endmodule

// File: rtl/rfsh_fsm.sv
// Refresh sequence control: idle -> drain -> precharge -> run -> idle.
// Assumes: done strobes arrive only in response to the matching request.
module rfsh_fsm
    import rfsh_pkg::*;
#(
    parameter int INFL_W = 4,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              due_i,
    input  logic [INFL_W-1:0] inflight_i,
    input  logic [BANK_W-1:0] open_banks_i,
    input  logic              prea_done_i,
    input  logic              run_active_i,
    input  logic              run_expire_i,
    output rfsh_state_e       state_o,
    output logic              avail_o,
    output logic              prea_req_o,
    output logic              ref_req_o
);
    rfsh_state_e st_q, st_d;

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        case (st_q)
            RS_IDLE:  if (due_i) st_d = RS_DRAIN;
            RS_DRAIN: if (inflight_i == '0) st_d = RS_PRECH;
            RS_PRECH: if (open_banks_i == '0 || prea_done_i) st_d = RS_RUN;
            RS_RUN:   if (run_expire_i) st_d = RS_IDLE;
            default:  st_d = RS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RS_IDLE;
        else        st_q <= st_d;
    end

    assign state_o    = st_q;
    assign avail_o    = (st_q == RS_IDLE);
    assign prea_req_o = (st_q == RS_PRECH) && (open_banks_i != '0);
    assign ref_req_o  = (st_q == RS_RUN) && !run_active_i;

    // R2
    drain_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_DRAIN && $past(st_q) == RS_IDLE) |-> $past(due_i));
    // R3
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_DRAIN && inflight_i != '0) |=> st_q == RS_DRAIN);
    // R4
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_RUN && $past(st_q) != RS_RUN) |-> $past(st_q) == RS_PRECH);
    // R5
    prea_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prea_req_o |-> open_banks_i != '0);
    // R7
    req_unavail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prea_req_o || ref_req_o) |-> !avail_o);
endmodule

// File: rtl/rank_refresh_seq.sv
// Per-rank refresh sequencer top: joins the due-time tracker, the refresh
// cycle timer and the sequence control.
// Assumes: one instance per rank; its ports carry only this rank's counts and strobes.
module rank_refresh_seq
    import rfsh_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int RC_W   = 8,
    parameter int INFL_W = 4,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  first_due_i,
    input  logic [CNT_W-1:0]  interval_i,
    input  logic [RC_W-1:0]   trc_i,
    input  logic [INFL_W-1:0] inflight_i,
    input  logic [BANK_W-1:0] open_banks_i,
    input  logic              prea_done_i,
    input  logic              ref_done_i,
    output logic              avail_o,
    output logic              prea_req_o,
    output logic              ref_req_o,
    output logic [1:0]        state_o
);
    logic        due;
    logic        run_active;
    logic        run_expire;
    logic        run_start;
    rfsh_state_e st;

    assign run_start = ref_req_o & ref_done_i;
    assign state_o   = st;

    rfsh_due_timer #(.CNT_W(CNT_W)) u_due (
        .clk(clk), .rst_n(rst_n), .first_due_i(first_due_i),
        .interval_i(interval_i), .idle_i(avail_o), .due_o(due)
    );

    rfsh_run_timer #(.RC_W(RC_W)) u_run (
        .clk(clk), .rst_n(rst_n), .start_i(run_start), .trc_i(trc_i),
        .active_o(run_active), .expire_o(run_expire)
    );

    rfsh_fsm #(.INFL_W(INFL_W), .BANK_W(BANK_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .due_i(due), .inflight_i(inflight_i),
        .open_banks_i(open_banks_i), .prea_done_i(prea_done_i),
        .run_active_i(run_active), .run_expire_i(run_expire),
        .state_o(st), .avail_o(avail_o), .prea_req_o(prea_req_o),
        .ref_req_o(ref_req_o)
    );
endmodule

// File: tb/test_rank_refresh_seq.sv
module test_rank_refresh_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] first_due_i = 16'd5;
    logic [15:0] interval_i = 16'd60;
    logic [7:0]  trc_i = 8'd2;
    logic [3:0]  inflight_i = 4'd3;
    logic [3:0]  open_banks_i = 4'd0;
    logic        prea_done_i = 1'b0;
    logic        ref_done_i = 1'b0;
    logic        avail_o, prea_req_o, ref_req_o;
    logic [1:0]  state_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rel = 0;

    // columns: first due, interval, drain hold, open banks, precharge latency, trc
    localparam int NCASE = 4;
    localparam int TBL [NCASE][6] = '{
        '{5,  60, 3, 2, 2, 4},
        '{8,  50, 0, 0, 0, 1},
        '{3,  70, 6, 5, 0, 0},
        '{12, 55, 1, 1, 4, 7}
    };

    rank_refresh_seq i_rank_refresh_seq (
        .clk(clk), .rst_n(rst_n), .first_due_i(first_due_i), .interval_i(interval_i),
        .trc_i(trc_i), .inflight_i(inflight_i), .open_banks_i(open_banks_i),
        .prea_done_i(prea_done_i), .ref_done_i(ref_done_i), .avail_o(avail_o),
        .prea_req_o(prea_req_o), .ref_req_o(ref_req_o), .state_o(state_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start(int d, int itv, int b, int t);
        rst_n = 1'b0;
        first_due_i = 16'(d); interval_i = 16'(itv);
        open_banks_i = 4'(b); trc_i = 8'(t);
        inflight_i = 4'd3; prea_done_i = 1'b0; ref_done_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rel = cyc;
    endtask

    task automatic wait_drop();
        int g = 0;
        while (avail_o && g < 5000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic finish_ref(int t, output int n);
        @(negedge clk);
        chk("R6 ref_req held", ref_req_o, 1);
        ref_done_i = 1'b1;
        @(negedge clk);
        ref_done_i = 1'b0;
        chk("R6 ref_req drop", ref_req_o, 0);
        n = 0;
        while (!avail_o && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        // R1 reset state
        @(negedge clk);
        chk("R1 state", state_o, 0);
        chk("R1 avail", avail_o, 1);
        chk("R1 prea_req", prea_req_o, 0);
        chk("R1 ref_req", ref_req_o, 0);

        for (int k = 0; k < NCASE; k++) begin
            int d = TBL[k][0], itv = TBL[k][1], h = TBL[k][2];
            int b = TBL[k][3], l = TBL[k][4], t = TBL[k][5];
            start(d, itv, b, t);
            @(negedge clk);
            chk("R1 avail after release", avail_o, 1);
            wait_drop();
            // R2: inflight nonzero all through idle, drop exactly at due
            chk("R2 drop edge", cyc - rel, d + 1);
            chk("R3 drain state", state_o, 1);
            for (int j = 0; j < h; j++) begin
                @(negedge clk);
                chk("R3 drain hold", state_o, 1);
            end
            inflight_i = 4'd0;
            @(negedge clk);
            chk("R3 precharge state", state_o, 2);
            chk("R4 R5 prea_req", prea_req_o, (b != 0) ? 1 : 0);
            if (b != 0) begin
                for (int j = 0; j < l; j++) begin
                    @(negedge clk);
                    chk("R4 prea_req held", prea_req_o, 1);
                end
                prea_done_i = 1'b1;
                @(negedge clk);
                prea_done_i = 1'b0;
            end else begin
                @(negedge clk);
            end
            chk("R4 R5 run state", state_o, 3);
            chk("R6 ref_req", ref_req_o, 1);
            chk("R7 avail in run", avail_o, 0);
            finish_ref(t, n);
            chk("R6 run length", n, (t > 1) ? t : 1);
            chk("R7 idle state", state_o, 0);
            inflight_i = 4'd3;
            wait_drop();
            chk("R8 second drop edge", cyc - rel, d + itv + 1);
        end

        // R9: expiry during drain is remembered, one idle cycle then drain again
        start(4, 9, 0, 1);
        wait_drop();
        chk("R2 drop edge", cyc - rel, 5);
        for (int j = 0; j < 8; j++) @(negedge clk);
        inflight_i = 4'd0;
        @(negedge clk);
        @(negedge clk);
        chk("R5 run state", state_o, 3);
        finish_ref(1, n);
        chk("R9 run length", n, 1);
        @(negedge clk);
        chk("R9 avail one cycle", avail_o, 0);
        chk("R9 drain again", state_o, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule